// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block supervises link integrity for a bank of twisted-pair repeater ports. Each port has two independent halves. The transmit half watches the port's transmitter. When the transmitter has been silent for a fixed number of millisecond ticks, it raises a one-cycle request for a link pulse, so that the far end keeps seeing a live line. The receive half watches for incoming link pulses and data packets. After a long silence it declares the link failed. It restores the link once it sees enough evidence of life.

While a port's link-fail flag is high, the surrounding repeater logic keeps that port out of repeating in both directions. Link pulse requests do not depend on the receive state. Every port keeps getting them whether it is failed, checked or unchecked. A per-port control bit turns receive checking off for equipment that never sends link pulses. A port with checking off is held in the link-good state.

All timing is counted on a shared one-cycle `ms_tick` strobe, so the block runs from any core clock. The pulse request and the link-fail flag are plain status outputs with no handshake. The waveform generator downstream must accept a request in the cycle it appears.

Top module: `tp_link_monitor`

## Requirements
- R1: After reset, `link_fail` is high and `pulse_req` is low on every port.
- R2: Suppose a port sees IDLE_MS (default 16) `ms_tick` strobes with `tx_active` low throughout, counted from reset or from the last restart. Then its `pulse_req` goes high in the cycle after the last of those strobes, and it stays high for that one cycle only.
- R3: A cycle with `tx_active` high restarts that port's idle count. A port whose `tx_active` stays high never requests a pulse.
- R4: Each issued pulse request restarts the idle count, so an idle port requests a pulse every IDLE_MS ticks.
- R5: Pulse requests are produced the same way whether the port is in link fail, link good or has receive checking disabled.
- R6: With checking enabled, RX_TIMEOUT_MS (default 100) ticks with no `rx_pulse` or `rx_packet` on a port set its `link_fail` in the cycle after the last of those ticks.
- R7: Any `rx_pulse` or `rx_packet` on a port restarts its receive timeout count.
- R8: A failed port clears `link_fail` in the cycle after its RECOVER_PULSES-th (default 4) `rx_pulse` since it last failed, its pulse count was last cleared, or reset.
- R9: A single `rx_packet` on a failed port clears `link_fail` in the following cycle.
- R10: A receive timeout that occurs while a port is failed clears its partial pulse count. Recovery then needs a full RECOVER_PULSES new pulses.
- R11: When `rx_check_dis` is high on a port, that port's `link_fail` is low from the next cycle on, and no timeout sets it.
- R12: Ports are independent. Activity on one port changes no other port's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| tx_active | input | NPORTS | Per-port transmitter busy |
| rx_pulse | input | NPORTS | Per-port one-cycle strobe: a link pulse was received |
| rx_packet | input | NPORTS | Per-port one-cycle strobe: a data packet was received |
| rx_check_dis | input | NPORTS | Per-port receive link checking disable |
| pulse_req | output | NPORTS | Per-port one-cycle request to send a link pulse |
| link_fail | output | NPORTS | Per-port link-fail flag |

## Verification
The properties assume that `ms_tick`, `rx_pulse` and `rx_packet` are single-cycle strobes. They also assume that the inputs are quiet while reset is applied. This lets them relate each pulse request and each rise of `link_fail` to a tick in the previous cycle. The directed stimulus drives every strobe for exactly one cycle, with an idle cycle between strobes. It changes inputs only on the falling clock edge and holds them at zero during reset. As a result, every check falls on a known cycle and every tick or receive event is counted exactly once.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic {
    LT_FAIL = 1'b0,
    LT_GOOD = 1'b1
  } lt_state_e;

  typedef struct packed {
    logic pulse;
    logic packet;
  } lt_rx_evt_s;
endpackage

// File: rtl/lt_idle_timer.sv
module lt_idle_timer #(
  parameter int IDLE_MS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_active,
  output logic pulse_req
);
  localparam int IW = $clog2(IDLE_MS + 1);
  localparam logic [IW-1:0] LAST = IW'(IDLE_MS - 1);

  logic [IW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt  <= '0;
      pulse_req <= 1'b0;
    end else begin
      pulse_req <= 1'b0;
      if (tx_active) begin
        idle_cnt <= '0;
      end else if (tick) begin
        if (idle_cnt == LAST) begin
          idle_cnt  <= '0;
          pulse_req <= 1'b1;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lt_rx_watchdog.sv
module lt_rx_watchdog #(
  parameter int TIMEOUT_MS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_seen,
  output logic expire
);
  localparam int TW = $clog2(TIMEOUT_MS + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_MS - 1);

  logic [TW-1:0] quiet_cnt;

  assign expire = tick && !rx_seen && (quiet_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet_cnt <= '0;
    end else if (rx_seen || expire) begin
      quiet_cnt <= '0;
    end else if (tick) begin
      quiet_cnt <= quiet_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lt_link_fsm.sv
module lt_link_fsm
  import lt_pkg::*;
#(
  parameter int RECOVER_PULSES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  lt_rx_evt_s rx_evt,
  input  logic       check_dis,
  output logic       link_fail
);
  localparam int PW = $clog2(RECOVER_PULSES + 1);
  localparam logic [PW-1:0] LAST = PW'(RECOVER_PULSES - 1);

  lt_state_e     state_q, state_d;
  logic [PW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    state_d = state_q;
    pcnt_d  = pcnt_q;
    if (check_dis) begin
      state_d = LT_GOOD;
      pcnt_d  = '0;
    end else if (state_q == LT_FAIL) begin
      if (rx_evt.packet) begin
        state_d = LT_GOOD;
        pcnt_d  = '0;
      end else if (rx_evt.pulse) begin
        if (pcnt_q == LAST) begin
          state_d = LT_GOOD;
          pcnt_d  = '0;
        end else begin
          pcnt_d = pcnt_q + 1'b1;
        end
      end else if (expire) begin
        pcnt_d = '0;
      end
    end else if (expire) begin
      state_d = LT_FAIL;
      pcnt_d  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LT_FAIL;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign link_fail = (state_q == LT_FAIL);
endmodule

// File: rtl/lt_port.sv
module lt_port
  import lt_pkg::*;
#(
  parameter int IDLE_MS        = 16,
  parameter int RX_TIMEOUT_MS  = 100,
  parameter int RECOVER_PULSES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_active,
  input  logic rx_pulse,
  input  logic rx_packet,
  input  logic check_dis,
  output logic pulse_req,
  output logic link_fail
);
  lt_rx_evt_s evt;
  logic       expire;

  assign evt.pulse  = rx_pulse;
  assign evt.packet = rx_packet;

  lt_idle_timer #(.IDLE_MS(IDLE_MS)) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .tx_active (tx_active),
    .pulse_req (pulse_req)
  );

  lt_rx_watchdog #(.TIMEOUT_MS(RX_TIMEOUT_MS)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .rx_seen (rx_pulse | rx_packet),
    .expire  (expire)
  );

  lt_link_fsm #(.RECOVER_PULSES(RECOVER_PULSES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .rx_evt    (evt),
    .check_dis (check_dis),
    .link_fail (link_fail)
  );
endmodule

// File: rtl/tp_link_monitor.sv
module tp_link_monitor #(
  parameter int NPORTS         = 2,
  parameter int IDLE_MS        = 16,
  parameter int RX_TIMEOUT_MS  = 100,
  parameter int RECOVER_PULSES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic [NPORTS-1:0] tx_active,
  input  logic [NPORTS-1:0] rx_pulse,
  input  logic [NPORTS-1:0] rx_packet,
  input  logic [NPORTS-1:0] rx_check_dis,
  output logic [NPORTS-1:0] pulse_req,
  output logic [NPORTS-1:0] link_fail
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    lt_port #(
      .IDLE_MS        (IDLE_MS),
      .RX_TIMEOUT_MS  (RX_TIMEOUT_MS),
      .RECOVER_PULSES (RECOVER_PULSES)
    ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (ms_tick),
      .tx_active (tx_active[p]),
      .rx_pulse  (rx_pulse[p]),
      .rx_packet (rx_packet[p]),
      .check_dis (rx_check_dis[p]),
      .pulse_req (pulse_req[p]),
      .link_fail (link_fail[p])
    );
  end
endmodule

// File: rtl/tp_link_monitor_chk.sv
module tp_link_monitor_chk #(
  parameter int NPORTS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ms_tick,
  input logic [NPORTS-1:0] tx_active,
  input logic [NPORTS-1:0] rx_packet,
  input logic [NPORTS-1:0] rx_check_dis,
  input logic [NPORTS-1:0] pulse_req,
  input logic [NPORTS-1:0] link_fail
);
  // R2
  req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_req != '0) |=> ((pulse_req & $past(pulse_req)) == '0));

  // R2
  req_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_req != '0) |-> $past(ms_tick));

  // R3
  tx_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active != '0) |=> ((pulse_req & $past(tx_active)) == '0));

  // R6
  fail_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((link_fail & ~$past(link_fail)) != '0) |-> $past(ms_tick));

  // R9
  packet_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_packet != '0) |=> ((link_fail & $past(rx_packet)) == '0));

  // R11
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_check_dis != '0) |=> ((link_fail & $past(rx_check_dis)) == '0));
endmodule

bind tp_link_monitor tp_link_monitor_chk #(.NPORTS(NPORTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ms_tick      (ms_tick),
  .tx_active    (tx_active),
  .rx_packet    (rx_packet),
  .rx_check_dis (rx_check_dis),
  .pulse_req    (pulse_req),
  .link_fail    (link_fail)
);

// File: tb/sim_tp_link_monitor.sv
module sim_tp_link_monitor;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ms_tick = 1'b0;
  logic [NP-1:0] tx_active = '0;
  logic [NP-1:0] rx_pulse = '0;
  logic [NP-1:0] rx_packet = '0;
  logic [NP-1:0] rx_check_dis = '0;
  logic [NP-1:0] pulse_req;
  logic [NP-1:0] link_fail;

  int n_tests = 0;
  int n_fail  = 0;
  int pcnt [NP];

  always #4 clk = ~clk;

  tp_link_monitor #(.NPORTS(NP)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .ms_tick      (ms_tick),
    .tx_active    (tx_active),
    .rx_pulse     (rx_pulse),
    .rx_packet    (rx_packet),
    .rx_check_dis (rx_check_dis),
    .pulse_req    (pulse_req),
    .link_fail    (link_fail)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    n_tests++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ms_tick = 1'b0;
    tx_active = '0;
    rx_pulse = '0;
    rx_packet = '0;
    rx_check_dis = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < NP; p++) pcnt[p] = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
      for (int p = 0; p < NP; p++) pcnt[p] += int'(pulse_req[p]);
    end
  endtask

  task automatic lpulse(input int p);
    @(negedge clk) rx_pulse[p] = 1'b1;
    @(negedge clk) rx_pulse[p] = 1'b0;
  endtask

  task automatic lpacket(input int p);
    @(negedge clk) rx_packet[p] = 1'b1;
    @(negedge clk) rx_packet[p] = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 link_fail", int'(link_fail), 3);
    chk("R1 pulse_req", int'(pulse_req), 0);
  endtask

  task automatic t_idle();
    do_reset();
    ticks(15);
    chk("R2 no pulse before limit", pcnt[0] + pcnt[1], 0);
    ticks(1);
    chk("R2 pulse after limit (R5 ports in fail)", int'(pulse_req), 3);
    @(negedge clk);
    chk("R2 pulse one cycle", int'(pulse_req), 0);
    for (int p = 0; p < NP; p++) pcnt[p] = 0;
    ticks(32);
    chk("R4 periodic pulses port0", pcnt[0], 2);
    chk("R4 periodic pulses port1", pcnt[1], 2);
  endtask

  task automatic t_tx();
    do_reset();
    ticks(10);
    @(negedge clk) tx_active[0] = 1'b1;
    @(negedge clk) tx_active[0] = 1'b0;
    ticks(15);
    chk("R3 restart port0", pcnt[0], 0);
    chk("R12 port1 unaffected", pcnt[1], 1);
    ticks(1);
    chk("R3 pulse after restart", int'(pulse_req[0]), 1);
    for (int p = 0; p < NP; p++) pcnt[p] = 0;
    tx_active[0] = 1'b1;
    ticks(40);
    tx_active[0] = 1'b0;
    chk("R3 busy tx no pulse", pcnt[0], 0);
  endtask

  task automatic t_packet();
    do_reset();
    lpacket(1);
    chk("R9 packet restores port1", int'(link_fail[1]), 0);
    chk("R12 port0 still failed", int'(link_fail[0]), 1);
  endtask

  task automatic t_pulses();
    do_reset();
    lpulse(0); lpulse(0); lpulse(0);
    chk("R8 three pulses not enough", int'(link_fail[0]), 1);
    lpulse(0);
    chk("R8 fourth pulse restores", int'(link_fail[0]), 0);
    ticks(99);
    chk("R6 no fail before timeout", int'(link_fail[0]), 0);
    ticks(1);
    chk("R6 fail at timeout", int'(link_fail[0]), 1);
  endtask

  task automatic t_rx_restart();
    do_reset();
    lpacket(0);
    ticks(60);
    lpulse(0);
    ticks(99);
    chk("R7 event restarts timeout", int'(link_fail[0]), 0);
    ticks(1);
    chk("R7 timeout after restart", int'(link_fail[0]), 1);
  endtask

  task automatic t_count_clear();
    do_reset();
    lpulse(0); lpulse(0); lpulse(0);
    ticks(100);
    chk("R10 still failed after timeout", int'(link_fail[0]), 1);
    lpulse(0);
    chk("R10 count was cleared", int'(link_fail[0]), 1);
    lpulse(0); lpulse(0); lpulse(0);
    chk("R10 four fresh pulses restore", int'(link_fail[0]), 0);
  endtask

  task automatic t_disable();
    do_reset();
    @(negedge clk) rx_check_dis[0] = 1'b1;
    @(negedge clk);
    chk("R11 disable clears fail", int'(link_fail[0]), 0);
    for (int p = 0; p < NP; p++) pcnt[p] = 0;
    ticks(250);
    chk("R11 no fail while disabled", int'(link_fail[0]), 0);
    chk("R12 other port still failed", int'(link_fail[1]), 1);
    chk("R5 pulses with check disabled", pcnt[0], 15);
    chk("R5 pulses while in fail", pcnt[1], 15);
    @(negedge clk) begin
      rx_check_dis[0] = 1'b0;
      rx_pulse[0] = 1'b1;
    end
    @(negedge clk) rx_pulse[0] = 1'b0;
    ticks(99);
    chk("R11 re-enabled no early fail", int'(link_fail[0]), 0);
    ticks(1);
    chk("R11 re-enabled times out", int'(link_fail[0]), 1);
  endtask

  initial begin
    #(200000 * 8);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_tx();
    t_packet();
    t_pulses();
    t_rx_restart();
    t_count_clear();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule